// File: doc/BRIEF.md
# Embedded Controller Host Port

This block is the device end of a byte-wide host link into an embedded controller's internal register space. The host sees two addresses. Offset 0 is the data port. Offset 4 returns a status byte when read and accepts a command byte when written. Every host transaction is a short exchange of a command byte, then address and data bytes. The exchange is paced by two flags: an input-buffer-full flag, held while a written byte waits to be consumed, and an output-buffer-full flag, held while a reply byte waits for the host.

Each written byte is taken into a one-byte input buffer. It is consumed after a programmable number of cycles, which models the controller's firmware latency. A small sequencer decodes the command and then drives a simple local read/write port into a 256-entry register array that sits outside the block. Reply bytes go into a one-byte output buffer. The sequencer also handles the burst enable and burst disable commands, which only change a status flag, and a query command that returns an event code supplied at an input.

Top module: `ec_host_port`

## Requirements
- R1: When `host_addr` is 4, `host_rdata` shows the status byte: bit 0 output-buffer-full, bit 1 input-buffer-full, bit 3 command flag, bit 4 burst flag, and all other bits 0. After reset the status byte is 0x00.
- R2: A write accepted at a clock edge sets input-buffer-full after that edge. With latency `lat_cfg` = L captured at acceptance, the flag stays high for exactly L+1 cycles, and the byte is consumed at the edge that clears it.
- R3: A host write that arrives while input-buffer-full is set is dropped. It changes neither the buffered byte nor the command flag.
- R4: Command 0x80 followed by an address byte on the data port reads that register when the address byte is consumed. The read pulses `reg_rd` for one cycle, places `reg_rdata` in the output buffer and sets output-buffer-full.
- R5: Command 0x81, then an address byte, then a data byte produces exactly one `reg_wr` pulse, carrying that address and that data, when the data byte is consumed.
- R6: When `host_addr` is 0, `host_rdata` shows the output buffer. A host read (`host_rd`) at offset 0 clears output-buffer-full.
- R7: Command 0x82 sets the burst flag and loads the acknowledge byte 0x90 with output-buffer-full set. Command 0x83 clears the burst flag and loads no reply.
- R8: Command 0x84 loads the value of `event_code` into the output buffer and sets output-buffer-full.
- R9: A data-port byte consumed while no command is pending causes no register access and no reply.
- R10: A command byte abandons any partly received read or write sequence.
- R11: The command flag is 1 when the last accepted byte was written at offset 4 and 0 when it was written at offset 0.
- R12: Host writes to any offset other than 0 or 4 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe; at offset 0 it drains the output buffer |
| host_addr | input | 3 | Host offset: 0 for data, 4 for status/command |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Status byte or output buffer, selected by `host_addr` |
| lat_cfg | input | LAT_W | Consume latency in cycles, captured with each accepted byte |
| event_code | input | 8 | Byte returned by the query command |
| reg_rd | output | 1 | Local register read strobe |
| reg_wr | output | 1 | Local register write strobe |
| reg_addr | output | AW | Local register address |
| reg_wdata | output | 8 | Local register write data |
| reg_rdata | input | 8 | Local register read data, valid in the same cycle as `reg_rd` |

## Verification
The bench builds the block with LAT_W set to 4 and AW left at 8, so the whole 256-entry register space can be reached. The bench switches `lat_cfg` between 0, 3 and 5. A latency of 0 gives back-to-back consumption, where each byte is consumed at the edge right after it is accepted. A latency of 3 lets the bench count the exact length of the input-buffer-full window. A latency of 5 leaves room to push a second byte into a full buffer and then show that it was dropped.

// File: rtl/ec_pkg.sv
package ec_pkg;
  localparam int unsigned OFS_DATA = 0;
  localparam int unsigned OFS_CSR  = 4;

  localparam logic [7:0] CMD_READ   = 8'h80;
  localparam logic [7:0] CMD_WRITE  = 8'h81;
  localparam logic [7:0] CMD_BST_ON = 8'h82;
  localparam logic [7:0] CMD_BST_OFF = 8'h83;
  localparam logic [7:0] CMD_QUERY  = 8'h84;
  localparam logic [7:0] BURST_ACK  = 8'h90;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_RD_ADDR,
    SQ_WR_ADDR,
    SQ_WR_DATA
  } seq_t;

  // status byte layout: 0 obf, 1 ibf, 3 command flag, 4 burst
  function automatic logic [7:0] pack_status(input logic obf, input logic ibf,
                                             input logic cmd, input logic burst);
    return {3'b000, burst, cmd, 1'b0, ibf, obf};
  endfunction

  function automatic logic offset_hit(input logic [2:0] a);
    return (a == 3'(OFS_DATA)) || (a == 3'(OFS_CSR));
  endfunction
endpackage

// File: rtl/ec_inbuf.sv
module ec_inbuf #(
  parameter int unsigned LAT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [7:0]       wdata,
  input  logic             wr_is_cmd,
  input  logic [LAT_W-1:0] lat_cfg,
  output logic             ibf,
  output logic [7:0]       byte_q,
  output logic             is_cmd_q,
  output logic             consume
);
  logic [LAT_W-1:0] wait_cnt;

  assign consume = ibf && (wait_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ibf      <= 1'b0;
      byte_q   <= '0;
      is_cmd_q <= 1'b0;
      wait_cnt <= '0;
    end else if (accept) begin
      ibf      <= 1'b1;
      byte_q   <= wdata;
      is_cmd_q <= wr_is_cmd;
      wait_cnt <= lat_cfg;
    end else if (ibf) begin
      if (wait_cnt != '0) wait_cnt <= wait_cnt - 1'b1;
      else                ibf      <= 1'b0;
    end
  end
endmodule

// File: rtl/ec_seq.sv
module ec_seq
  import ec_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          consume,
  input  logic [7:0]    byte_val,
  input  logic          byte_is_cmd,
  input  logic [7:0]    reg_rdata,
  input  logic [7:0]    event_code,
  output logic          reg_rd,
  output logic          reg_wr,
  output logic [AW-1:0] reg_addr,
  output logic [7:0]    reg_wdata,
  output logic          obuf_load,
  output logic [7:0]    obuf_val,
  output logic          burst
);
  seq_t          state;
  logic [AW-1:0] addr_q;

  assign reg_addr  = (state == SQ_WR_DATA) ? addr_q : byte_val[AW-1:0];
  assign reg_wdata = byte_val;

  always_comb begin
    reg_rd    = 1'b0;
    reg_wr    = 1'b0;
    obuf_load = 1'b0;
    obuf_val  = reg_rdata;
    if (consume && byte_is_cmd) begin
      if (byte_val == CMD_BST_ON) begin
        obuf_load = 1'b1;
        obuf_val  = BURST_ACK;
      end else if (byte_val == CMD_QUERY) begin
        obuf_load = 1'b1;
        obuf_val  = event_code;
      end
    end else if (consume) begin
      if (state == SQ_RD_ADDR) begin
        reg_rd    = 1'b1;
        obuf_load = 1'b1;
      end else if (state == SQ_WR_DATA) begin
        reg_wr = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      addr_q <= '0;
      burst  <= 1'b0;
    end else if (consume && byte_is_cmd) begin
      case (byte_val)
        CMD_READ:    state <= SQ_RD_ADDR;
        CMD_WRITE:   state <= SQ_WR_ADDR;
        CMD_BST_ON:  begin state <= SQ_IDLE; burst <= 1'b1; end
        CMD_BST_OFF: begin state <= SQ_IDLE; burst <= 1'b0; end
        default:     state <= SQ_IDLE;
      endcase
    end else if (consume) begin
      case (state)
        SQ_WR_ADDR: begin
          addr_q <= byte_val[AW-1:0];
          state  <= SQ_WR_DATA;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ec_outbuf.sv
module ec_outbuf (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       drain,
  output logic       obf,
  output logic [7:0] obuf
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      obf  <= 1'b0;
      obuf <= '0;
    end else if (load) begin
      obf  <= 1'b1;
      obuf <= load_val;
    end else if (drain) begin
      obf <= 1'b0;
    end
  end
endmodule

// File: rtl/ec_host_port.sv
module ec_host_port
  import ec_pkg::*;
#(
  parameter int unsigned LAT_W = 10,
  parameter int unsigned AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [2:0]       host_addr,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  input  logic [LAT_W-1:0] lat_cfg,
  input  logic [7:0]       event_code,
  output logic             reg_rd,
  output logic             reg_wr,
  output logic [AW-1:0]    reg_addr,
  output logic [7:0]       reg_wdata,
  input  logic [7:0]       reg_rdata
);
  logic       ibf, obf, cmd_flag, burst;
  logic       wr_accept, consume, obuf_load, drain;
  logic [7:0] byte_val, obuf_val, obuf;
  logic       at_csr;

  assign at_csr    = (host_addr == 3'(OFS_CSR));
  assign wr_accept = host_wr && !ibf && offset_hit(host_addr);
  assign drain     = host_rd && (host_addr == 3'(OFS_DATA));

  ec_inbuf #(.LAT_W(LAT_W)) u_inbuf (
    .clk(clk), .rst_n(rst_n), .accept(wr_accept), .wdata(host_wdata),
    .wr_is_cmd(at_csr), .lat_cfg(lat_cfg), .ibf(ibf), .byte_q(byte_val),
    .is_cmd_q(cmd_flag), .consume(consume)
  );

  ec_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .consume(consume), .byte_val(byte_val),
    .byte_is_cmd(cmd_flag), .reg_rdata(reg_rdata), .event_code(event_code),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .obuf_load(obuf_load), .obuf_val(obuf_val),
    .burst(burst)
  );

  ec_outbuf u_outbuf (
    .clk(clk), .rst_n(rst_n), .load(obuf_load), .load_val(obuf_val),
    .drain(drain), .obf(obf), .obuf(obuf)
  );

  assign host_rdata = at_csr ? pack_status(obf, ibf, cmd_flag, burst) : obuf;
endmodule

// File: rtl/ec_host_port_chk.sv
module ec_host_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr,
  input logic       host_rd,
  input logic [2:0] host_addr,
  input logic       ibf,
  input logic       obf,
  input logic       cmd_flag,
  input logic       burst,
  input logic       reg_rd,
  input logic       reg_wr,
  input logic       consume,
  input logic       obuf_load,
  input logic [7:0] byte_val
);
  // R2
  ibf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !ibf && (host_addr == 3'd0 || host_addr == 3'd4)) |=> ibf);

  // R3
  drop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && ibf) |=> $stable(cmd_flag));

  // R4
  read_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> obf);

  // R5
  write_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !ibf);

  // R6
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 3'd0 && !obuf_load) |=> !obf);

  // R7
  burst_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && cmd_flag && byte_val == 8'h82) |=> (burst && obf));
endmodule

bind ec_host_port ec_host_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
  .host_addr(host_addr), .ibf(ibf), .obf(obf), .cmd_flag(cmd_flag),
  .burst(burst), .reg_rd(reg_rd), .reg_wr(reg_wr), .consume(consume),
  .obuf_load(obuf_load), .byte_val(byte_val)
);

// File: tb/tb_ec_host_port.sv
module tb_ec_host_port;
  localparam int LAT_W = 4;
  localparam int AW    = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             host_wr = 1'b0, host_rd = 1'b0;
  logic [2:0]       host_addr = 3'd4;
  logic [7:0]       host_wdata = '0;
  logic [7:0]       host_rdata;
  logic [LAT_W-1:0] lat_cfg = '0;
  logic [7:0]       event_code = 8'h5C;
  logic             reg_rd, reg_wr;
  logic [AW-1:0]    reg_addr;
  logic [7:0]       reg_wdata, reg_rdata;

  logic [7:0] mem [256];
  int checks = 0, errors = 0, cycles = 0, rd_cnt = 0;
  logic [7:0]  exp_q[$];
  logic [15:0] wr_q[$];

  always #10 clk = ~clk;

  ec_host_port #(.LAT_W(LAT_W), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .lat_cfg(lat_cfg), .event_code(event_code), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) if (reg_wr) mem[reg_addr] <= reg_wdata;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: host data reads and local writes
  always @(negedge clk) begin
    if (rst_n && host_rd && host_addr == 3'd0) begin
      if (exp_q.size() == 0) chk(0, "R6 unexpected read", host_rdata, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(host_rdata == e, "R4/R6/R7/R8 data", host_rdata, e);
      end
    end
    if (rst_n && reg_rd) rd_cnt++;
    if (rst_n && reg_wr) begin
      if (wr_q.size() == 0) chk(0, "R5/R9/R10 unexpected reg_wr", {reg_addr, reg_wdata}, 0);
      else begin
        logic [15:0] w;
        w = wr_q.pop_front();
        chk({reg_addr, reg_wdata} == w, "R5 reg_wr", {reg_addr, reg_wdata}, w);
      end
    end
  end

  task automatic drive_wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #2 host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); #2 host_wr = 1'b0; host_addr = 3'd4;
  endtask

  task automatic wait_ibf_clr();
    do @(negedge clk); while (host_rdata[1]);
  endtask

  task automatic host_write(input logic [2:0] a, input logic [7:0] d);
    wait_ibf_clr();
    drive_wr(a, d);
  endtask

  task automatic expect_read(input logic [7:0] e);
    exp_q.push_back(e);
    wait_ibf_clr();
    while (!host_rdata[0]) @(negedge clk);
    @(posedge clk); #2 host_rd = 1'b1; host_addr = 3'd0;
    @(posedge clk); #2 host_rd = 1'b0; host_addr = 3'd4;
  endtask

  task automatic status(output logic [7:0] s);
    @(negedge clk); s = host_rdata;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] s;
    int n, rd0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 reset status
    status(s);
    chk(s == 8'h00, "R1 reset status", s, 8'h00);

    // R2 ibf window with latency 3
    lat_cfg = 4'd3;
    drive_wr(3'd4, 8'h83);
    n = 0;
    status(s);
    while (s[1]) begin n++; status(s); end
    chk(n == 4, "R2 ibf cycles", n, 4);
    // R11 command flag after command byte
    chk(s[3] == 1'b1, "R11 cmd flag set", s[3], 1);

    // R4 read sequence, latency 0
    lat_cfg = 4'd0;
    host_write(3'd4, 8'h80);
    host_write(3'd0, 8'h12);
    wait_ibf_clr();
    status(s);
    chk(s == 8'h01, "R4 obf after read", s, 8'h01);
    // R11 command flag after data byte
    chk(s[3] == 1'b0, "R11 cmd flag clear", s[3], 0);
    expect_read(mem[8'h12]);
    status(s);
    chk(s[0] == 1'b0, "R6 obf cleared", s[0], 0);

    // R5 write then read back
    lat_cfg = 4'd3;
    wr_q.push_back({8'h34, 8'hA5});
    host_write(3'd4, 8'h81);
    host_write(3'd0, 8'h34);
    host_write(3'd0, 8'hA5);
    wait_ibf_clr();
    host_write(3'd4, 8'h80);
    host_write(3'd0, 8'h34);
    expect_read(8'hA5);

    // R7 burst on / off
    host_write(3'd4, 8'h82);
    expect_read(8'h90);
    status(s);
    chk(s[4] == 1'b1, "R7 burst set", s[4], 1);
    host_write(3'd4, 8'h83);
    wait_ibf_clr();
    status(s);
    chk(s[4] == 1'b0 && s[0] == 1'b0, "R7 burst clear no reply", s, 8'h08);

    // R8 query
    host_write(3'd4, 8'h84);
    expect_read(8'h5C);

    // R9 data byte with nothing pending
    rd0 = rd_cnt;
    host_write(3'd0, 8'h77);
    wait_ibf_clr();
    status(s);
    chk(s[0] == 1'b0 && rd_cnt == rd0, "R9 idle data ignored", s, 0);

    // R10 write aborted by read command
    host_write(3'd4, 8'h81);
    host_write(3'd0, 8'h40);
    host_write(3'd4, 8'h80);
    host_write(3'd0, 8'h40);
    expect_read(mem[8'h40]);
    chk(mem[8'h40] == 8'(8'h40 * 7 + 3), "R10 no write after abort", mem[8'h40], 8'(8'h40 * 7 + 3));

    // R3 write into full buffer dropped
    lat_cfg = 4'd5;
    wr_q.push_back({8'h50, 8'h66});
    host_write(3'd4, 8'h81);
    drive_wr(3'd0, 8'h55);
    status(s);
    chk(s[1] == 1'b1 && s[3] == 1'b1, "R3 dropped keeps cmd flag", s, 8'h0A);
    host_write(3'd0, 8'h50);
    host_write(3'd0, 8'h66);
    wait_ibf_clr();
    chk(mem[8'h50] == 8'h66, "R3 sequence intact", mem[8'h50], 8'h66);

    // R12 other offset ignored
    drive_wr(3'd2, 8'h84);
    status(s);
    chk(s[1] == 1'b0 && s[0] == 1'b0, "R12 offset 2 ignored", s, 0);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R4 reads pending", exp_q.size(), 0);
    chk(wr_q.size() == 0, "R5 writes pending", wr_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule